// File: doc/BRIEF.md
# General-Purpose Port with Power-Mode Control Bits

This block is an 8-bit register interface for a six-pin bidirectional port. It sits on a simple memory-mapped register bus. Three registers are visible: an output value register, a direction register and a read-only pin sample register. Bits 0 to 5 of the output and direction registers control the six pads. A direction bit of 1 drives the pad from the output value bit. A direction bit of 0 leaves the pad as an input. The pin register returns the pad levels after a configurable synchronizer chain.

The two top bit positions do not control pads. In the output value register, they are write strobes. Writing a 1 to bit 7 requests the halt power mode. Writing a 1 to bit 6 requests the idle power mode. Each request appears as a one-cycle pulse, and these bits always read back as zero. In the direction register, bit 6 is a stored level that selects the alternate phase of the serial shift clock. Bit 7 of the direction register is unused.

The clock gating and halt sequencing, the serial shifter and the pads are outside the block. They consume the `halt_req`, `idle_req` and `sclk_alt` outputs.

Top module: `gpio_ctl_port`

## Requirements
- R1: After reset, the output value register, the direction register and the clock-phase bit are all 0. Every register reads 0, `pad_oe` is 0, `sclk_alt` is 0, and `halt_req` and `idle_req` are 0.
- R2: A bus write (`bus_en`=1, `bus_we`=1) to address 0 stores `bus_wdata[5:0]` in the output value register. From the next clock edge, `pad_out` shows the stored value. A read of address 0 returns it in bits 5:0, with bits 7:6 always 0.
- R3: A bus write to address 1 stores `bus_wdata[5:0]` in the direction register. From the next clock edge, `pad_oe` shows the stored value, and a read of address 1 returns it in bits 5:0.
- R4: A write to address 0 with bit 7 set makes `halt_req` 1 for exactly the one cycle that follows the write edge.
- R5: A write to address 0 with bit 6 set and bit 7 clear makes `idle_req` 1 for exactly the one cycle that follows the write edge.
- R6: A write to address 0 with both bit 7 and bit 6 set raises only `halt_req`. `halt_req` and `idle_req` are never 1 together.
- R7: Bit 6 of a write to address 1 is stored and drives `sclk_alt` as a level. It reads back at bit 6 of address 1. Bit 7 of address 1 is ignored and reads 0.
- R8: A read of address 2 returns `pad_in[5:0]` as sampled through `SYNC_STAGES` flip-flops. A pad change first becomes visible after exactly `SYNC_STAGES` rising edges (2 by default). Bits 7:6 read 0.
- R9: A bus cycle with `bus_en`=0 or `bus_we`=0 changes no register, and neither does a write to address 2 or 3. Address 3 and any cycle with `bus_en`=0 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus cycle select |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 output value, 1 direction, 2 pin sample, 3 reserved |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pad_in | input | 6 | Pad input levels (asynchronous) |
| pad_out | output | 6 | Pad output values |
| pad_oe | output | 6 | Pad output enables |
| halt_req | output | 1 | One-cycle halt-mode request |
| idle_req | output | 1 | One-cycle idle-mode request |
| sclk_alt | output | 1 | Alternate serial clock phase select |

## Verification
The port bits are written with alternating patterns (0x2A, 0x15) and with all ones. These patterns would expose a swapped or dropped bit between the register, the pad outputs and the read path. The top bits are written alone and together, with a nonzero low field alongside. This separates a correct halt/idle priority from simple OR logic and shows that the strobe bits leave the stored field intact. Pad changes are sampled one edge before and at the synchronizer depth, which pins down the latency exactly. Writes with the enable or the write flag low, and writes to the pin and reserved addresses, must leave all readable state unchanged.

// File: rtl/gpio_ctl_pkg.sv
package gpio_ctl_pkg;

   localparam int unsigned ADDR_W = 2;

   typedef enum logic [ADDR_W-1:0] {
      REG_OUTVAL = 2'd0,
      REG_DIR    = 2'd1,
      REG_PINS   = 2'd2,
      REG_RSVD   = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/gpio_ctl_sync.sv
module gpio_ctl_sync #(
   parameter int unsigned WIDTH  = 6,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   if (WIDTH < 1) begin : g_bad_width
      $error("gpio_ctl_sync: WIDTH must be at least 1");
   end

   if (STAGES == 0) begin : g_bypass
      assign sync_out = async_in;
   end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] stage_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            stage_q <= '0;
         end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
               stage_q[i] <= stage_q[i-1];
            end
         end
      end

      assign sync_out = stage_q[STAGES-1];

      if (STAGES >= 2) begin : g_chk
         AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (stage_q[1] == $past(stage_q[0]))) else $error("sync shift"); // R8
      end
   end

endmodule

// File: rtl/gpio_ctl_regs.sv
module gpio_ctl_regs #(
   parameter int unsigned IO_W   = 6,
   parameter int unsigned WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_outval,
   input  logic              wr_dir,
   input  logic [WORD_W-1:0] wdata,
   output logic [IO_W-1:0]   outval_q,
   output logic [IO_W-1:0]   dir_q,
   output logic              alt_q,
   output logic              halt_pulse,
   output logic              idle_pulse
);

   localparam int unsigned HALT_BIT = WORD_W - 1;
   localparam int unsigned IDLE_BIT = WORD_W - 2;
   localparam int unsigned ALT_BIT  = WORD_W - 2;

   if (IO_W + 2 != WORD_W) begin : g_bad_geom
      $error("gpio_ctl_regs: IO_W must be WORD_W-2");
   end

   logic halt_set;
   logic idle_set;

   assign halt_set = wr_outval && wdata[HALT_BIT];
   assign idle_set = wr_outval && wdata[IDLE_BIT] && !wdata[HALT_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         outval_q <= '0;
      end else if (wr_outval) begin
         outval_q <= wdata[IO_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q <= '0;
         alt_q <= 1'b0;
      end else if (wr_dir) begin
         dir_q <= wdata[IO_W-1:0];
         alt_q <= wdata[ALT_BIT];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         halt_pulse <= 1'b0;
         idle_pulse <= 1'b0;
      end else begin
         halt_pulse <= halt_set;
         idle_pulse <= idle_set;
      end
   end

   AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(halt_pulse && idle_pulse)) else $error("halt and idle together"); // R6
   AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      halt_pulse |-> $past(wr_outval)) else $error("halt without write"); // R4
   AST_IDLE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      idle_pulse |-> $past(wr_outval)) else $error("idle without write"); // R5
   AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_dir && $past(rst_n)) |=> $stable(dir_q) && $stable(alt_q)) else $error("dir changed"); // R9

endmodule

// File: rtl/gpio_ctl_rdmux.sv
module gpio_ctl_rdmux
   import gpio_ctl_pkg::*;
#(
   parameter int unsigned IO_W   = 6,
   parameter int unsigned WORD_W = 8
) (
   input  logic              rd_en,
   input  reg_sel_e          sel,
   input  logic [IO_W-1:0]   outval_q,
   input  logic [IO_W-1:0]   dir_q,
   input  logic              alt_q,
   input  logic [IO_W-1:0]   pins_q,
   output logic [WORD_W-1:0] rdata
);

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         unique case (sel)
            REG_OUTVAL: rdata[IO_W-1:0] = outval_q;
            REG_DIR: begin
               rdata[IO_W-1:0] = dir_q;
               rdata[IO_W]     = alt_q;
            end
            REG_PINS:   rdata[IO_W-1:0] = pins_q;
            default:    rdata = '0;
         endcase
      end
   end

   always_comb begin
      if (rd_en && sel == REG_OUTVAL) begin
         AST_STROBE_READ_ZERO: assert (rdata[WORD_W-1:IO_W] == '0) else $error("strobe bits read"); // R2
      end
   end

endmodule

// File: rtl/gpio_ctl_port.sv
module gpio_ctl_port
   import gpio_ctl_pkg::*;
#(
   parameter int unsigned IO_W        = 6,
   parameter int unsigned WORD_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   input  logic [IO_W-1:0]   pad_in,
   output logic [IO_W-1:0]   pad_out,
   output logic [IO_W-1:0]   pad_oe,
   output logic              halt_req,
   output logic              idle_req,
   output logic              sclk_alt
);

   if (IO_W + 2 != WORD_W) begin : g_bad_geom
      $error("gpio_ctl_port: two control bits must sit above the port bits");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("gpio_ctl_port: SYNC_STAGES above 4 not supported");
   end

   reg_sel_e         sel;
   logic             wr_outval;
   logic             wr_dir;
   logic             rd_en;
   logic [IO_W-1:0]  outval_q;
   logic [IO_W-1:0]  dir_q;
   logic [IO_W-1:0]  pins_q;

   assign sel       = reg_sel_e'(bus_addr);
   assign wr_outval = bus_en && bus_we && (sel == REG_OUTVAL);
   assign wr_dir    = bus_en && bus_we && (sel == REG_DIR);
   assign rd_en     = bus_en && !bus_we;

   gpio_ctl_regs #(
      .IO_W   (IO_W),
      .WORD_W (WORD_W)
   ) regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_outval  (wr_outval),
      .wr_dir     (wr_dir),
      .wdata      (bus_wdata),
      .outval_q   (outval_q),
      .dir_q      (dir_q),
      .alt_q      (sclk_alt),
      .halt_pulse (halt_req),
      .idle_pulse (idle_req)
   );

   gpio_ctl_sync #(
      .WIDTH  (IO_W),
      .STAGES (SYNC_STAGES)
   ) sync_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pad_in),
      .sync_out (pins_q)
   );

   gpio_ctl_rdmux #(
      .IO_W   (IO_W),
      .WORD_W (WORD_W)
   ) rdmux_i (
      .rd_en    (rd_en),
      .sel      (sel),
      .outval_q (outval_q),
      .dir_q    (dir_q),
      .alt_q    (sclk_alt),
      .pins_q   (pins_q),
      .rdata    (bus_rdata)
   );

   for (genvar b = 0; b < IO_W; b++) begin : g_pad
      assign pad_out[b] = outval_q[b];
      assign pad_oe[b]  = dir_q[b];
   end

   AST_HALT_FROM_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      halt_req |-> $past(bus_en && bus_we && bus_addr == 2'd0 && bus_wdata[WORD_W-1]))
      else $error("halt source"); // R4
   AST_IDLE_FROM_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      idle_req |-> $past(bus_en && bus_we && bus_addr == 2'd0 && bus_wdata[WORD_W-2] && !bus_wdata[WORD_W-1]))
      else $error("idle source"); // R5
   AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !(bus_en && bus_we && bus_addr == 2'd1)) |=> $stable(pad_oe))
      else $error("pad_oe changed without write"); // R3
   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !(bus_en && bus_we && bus_addr == 2'd0)) |=> $stable(pad_out))
      else $error("pad_out changed without write"); // R9

endmodule

// File: tb/gpio_ctl_port_tb.sv
module gpio_ctl_port_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_en = 1'b0;
   logic       bus_we = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [5:0] pad_in = '0;
   logic [5:0] pad_out;
   logic [5:0] pad_oe;
   logic       halt_req;
   logic       idle_req;
   logic       sclk_alt;

   int n_checks = 0;
   int n_errors = 0;
   logic h1, h2, i1, i2;

   always #4 clk = ~clk;

   gpio_ctl_port dut_i (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .halt_req(halt_req), .idle_req(idle_req), .sclk_alt(sclk_alt)
   );

   task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_errors++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
      end
   endtask

   // one bus cycle; records request outputs in the two cycles after the edge
   task automatic bus_cycle(input logic en, input logic we, input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      h1 = halt_req; i1 = idle_req;
      bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
      @(negedge clk);
      h2 = halt_req; i2 = idle_req;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_en = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check("R1 pad_oe", {2'b0, pad_oe}, 8'h00);
      check("R1 halt_req", {7'b0, halt_req}, 8'h00);
      check("R1 idle_req", {7'b0, idle_req}, 8'h00);
      check("R1 sclk_alt", {7'b0, sclk_alt}, 8'h00);
      reg_read(2'd0, d); check("R1 outval read", d, 8'h00);
      reg_read(2'd1, d); check("R1 dir read", d, 8'h00);
   endtask

   task automatic t_outval();
      logic [7:0] d;
      bus_cycle(1, 1, 2'd0, 8'h2A);
      check("R2 pad_out 2A", {2'b0, pad_out}, 8'h2A);
      reg_read(2'd0, d); check("R2 read 2A", d, 8'h2A);
      bus_cycle(1, 1, 2'd0, 8'h15);
      check("R2 pad_out 15", {2'b0, pad_out}, 8'h15);
      reg_read(2'd0, d); check("R2 read 15", d, 8'h15);
   endtask

   task automatic t_dir();
      logic [7:0] d;
      bus_cycle(1, 1, 2'd1, 8'h3F);
      check("R3 pad_oe 3F", {2'b0, pad_oe}, 8'h3F);
      reg_read(2'd1, d); check("R3 read 3F", d, 8'h3F);
      bus_cycle(1, 1, 2'd1, 8'h2A);
      check("R3 pad_oe 2A", {2'b0, pad_oe}, 8'h2A);
   endtask

   task automatic t_halt();
      logic [7:0] d;
      bus_cycle(1, 1, 2'd0, 8'h85);
      check("R4 halt pulse", {7'b0, h1}, 8'h01);
      check("R4 halt gone", {7'b0, h2}, 8'h00);
      check("R4 no idle", {7'b0, i1}, 8'h00);
      reg_read(2'd0, d); check("R4 strobe reads zero", d, 8'h05);
   endtask

   task automatic t_idle();
      logic [7:0] d;
      bus_cycle(1, 1, 2'd0, 8'h4A);
      check("R5 idle pulse", {7'b0, i1}, 8'h01);
      check("R5 idle gone", {7'b0, i2}, 8'h00);
      check("R5 no halt", {7'b0, h1}, 8'h00);
      reg_read(2'd0, d); check("R5 strobe reads zero", d, 8'h0A);
   endtask

   task automatic t_both();
      bus_cycle(1, 1, 2'd0, 8'hC0);
      check("R6 halt wins", {7'b0, h1}, 8'h01);
      check("R6 idle suppressed", {7'b0, i1}, 8'h00);
      check("R6 quiet after", {6'b0, h2, i2}, 8'h00);
   endtask

   task automatic t_alt();
      logic [7:0] d;
      bus_cycle(1, 1, 2'd1, 8'hC3);
      check("R7 sclk_alt set", {7'b0, sclk_alt}, 8'h01);
      reg_read(2'd1, d); check("R7 dir read bit7 zero", d, 8'h43);
      check("R7 alt no halt", {7'b0, h1}, 8'h00);
      bus_cycle(1, 1, 2'd1, 8'h83);
      check("R7 sclk_alt clear", {7'b0, sclk_alt}, 8'h00);
      reg_read(2'd1, d); check("R7 dir read 03", d, 8'h03);
   endtask

   task automatic t_pins();
      logic [7:0] d;
      @(negedge clk);
      pad_in = 6'h2D;
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = 2'd2;
      @(negedge clk); #1 d = bus_rdata;
      check("R8 one edge old", d, 8'h00);
      @(negedge clk); #1 d = bus_rdata;
      check("R8 two edges new", d, 8'h2D);
      bus_en = 1'b0;
      pad_in = 6'h3F;
      repeat (3) @(negedge clk);
      reg_read(2'd2, d); check("R8 all ones top zero", d, 8'h3F);
   endtask

   task automatic t_ignored();
      logic [7:0] d;
      bus_cycle(1, 1, 2'd0, 8'h15);
      bus_cycle(1, 1, 2'd1, 8'h0F);
      bus_cycle(0, 1, 2'd0, 8'hEA);
      check("R9 en low no halt", {7'b0, h1}, 8'h00);
      check("R9 en low pad_out", {2'b0, pad_out}, 8'h15);
      bus_cycle(1, 0, 2'd1, 8'h70);
      check("R9 we low pad_oe", {2'b0, pad_oe}, 8'h0F);
      check("R9 we low alt", {7'b0, sclk_alt}, 8'h00);
      bus_cycle(1, 1, 2'd2, 8'hFF);
      bus_cycle(1, 1, 2'd3, 8'hFF);
      check("R9 addr2/3 pad_out", {2'b0, pad_out}, 8'h15);
      check("R9 addr2/3 pad_oe", {2'b0, pad_oe}, 8'h0F);
      check("R9 addr2/3 no req", {6'b0, h1, i1}, 8'h00);
      reg_read(2'd3, d); check("R9 rsvd reads zero", d, 8'h00);
      @(negedge clk); bus_en = 1'b0; bus_addr = 2'd0; #1;
      check("R9 en low reads zero", bus_rdata, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_outval();
      t_dir();
      t_halt();
      t_idle();
      t_both();
      t_alt();
      t_pins();
      t_ignored();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule